// File: doc/BRIEF.md
# Streaming Packet Checker

This block sits at the receiving end of a 64-bit valid/ready word stream and checks each arriving packet against a packet it rebuilds from its own configuration inputs. The configuration describes the packet to expect: stream identifier, 12-bit sequence number, 16-bit byte size, burst-end and extension marks, and an optional 64-bit timestamp. A source that produces deterministic packets is connected to the stream input, the configuration is set to match, and the error outputs are read after the packet has passed.

Every accepted word is classified by its position in the packet: header, timestamp, full payload word, final word, or excess word after the final one. It is then compared with the expected value for that class. Header, timestamp, payload and framing problems each set their own sticky flag. A saturating counter counts the words that failed comparison, and a one-cycle completion pulse follows the word marked last. A state machine walks the packet with the states ST_HEAD, ST_TIME, ST_BODY, ST_TAIL and ST_DRAIN. From ST_HEAD an accepted word without last moves to ST_TIME when a timestamp is expected, otherwise to ST_BODY when full payload words are expected, otherwise to ST_TAIL. From ST_TIME it moves to ST_BODY or ST_TAIL on the same payload test. ST_BODY stays in place until the last full payload word is accepted, then moves to ST_TAIL. ST_TAIL moves to ST_DRAIN on a word without last. ST_DRAIN stays in place. From every state, a word marked last returns the machine to ST_HEAD.

Top module: `pkt_checker`

## Requirements
- R1: `s_ready` is high in every cycle after reset. A word is accepted only in a cycle where `s_valid` and `s_ready` are both high; data and last seen while `s_valid` is low change no output.
- R2: The first word of a packet must equal {ext, 1'b0, has_time, eob, seq_id[11:0], size[15:0], sid[31:0]}, MSB first. Any difference sets `err_header`.
- R3: When `cfg_has_time` is 1, the second word must equal `cfg_time`, and any difference sets `err_time`. When it is 0, the second word is treated as payload.
- R4: Payload word k (from 0) must hold four 16-bit lanes {j, j+1, j+2, j+3} with j = 4k, lane j in bits 63:48, lane values wrapping modulo 2^16. A difference sets `err_payload`.
- R5: The number of full payload words equals the number of byte indices that start at 16 (24 with a timestamp), step by 8 and stay below the size. Exactly one final payload word follows them and carries the pattern for the next k.
- R6: In the final word, only the (size mod 8) most significant bytes are compared, or all 8 when size mod 8 is 0. A difference in other bytes is ignored.
- R7: `err_frame` is set when last is seen on any word other than the final word, or when the final word arrives without last. Excess words after the final word are not compared.
- R8: All four error flags stay set until `clear` or reset. `clear` is synchronous, zeroes the flags and the counter, and wins over a mismatch in the same cycle.
- R9: `err_count` increases by one for each accepted word that fails a header, time or payload comparison (once per word, framing excluded) and saturates at 65535.
- R10: Flags and counter reflect an accepted word from the clock edge that accepts it. `done` is high for exactly the one cycle after the edge that accepts a word marked last.
- R11: The word after a word marked last is checked as the header of a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous clear of error flags and counter |
| cfg_seq_id | input | 12 | Expected sequence number |
| cfg_size | input | 16 | Expected packet size in bytes |
| cfg_has_time | input | 1 | A timestamp word follows the header |
| cfg_time | input | 64 | Expected timestamp |
| cfg_ext | input | 1 | Expected extension mark |
| cfg_eob | input | 1 | Expected burst-end mark |
| cfg_sid | input | 32 | Expected stream identifier |
| s_data | input | 64 | Stream data word |
| s_last | input | 1 | Marks the last word of a packet |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream ready, always high after reset |
| err_header | output | 1 | Sticky header mismatch flag |
| err_time | output | 1 | Sticky timestamp mismatch flag |
| err_payload | output | 1 | Sticky payload mismatch flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_count | output | 16 | Saturating count of mismatched words |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
Each word is driven on a falling edge and is accepted at the next rising edge. The flags and `err_count` change at that rising edge, so the bench reads them at the falling edge that follows, one cycle after the word was driven. `done` is registered at the same edge as the word marked last, so it is checked at that same falling edge and again one cycle later, when it must be low. For `clear`, the bench lets the rising edge pass before it reads the zeroed outputs.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_TIME,
        ST_BODY,
        ST_TAIL,
        ST_DRAIN
    } chk_state_t;

    typedef enum logic [2:0] {
        WC_HEAD,
        WC_TIME,
        WC_BODY,
        WC_TAIL,
        WC_EXTRA
    } word_cls_t;

endpackage

// File: rtl/pkt_chk_expect.sv
module pkt_chk_expect
    import pkt_chk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 16,
    parameter int IDX_W  = 16
) (
    input  logic [11:0]       cfg_seq_id,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              cfg_has_time,
    input  logic [63:0]       cfg_time,
    input  logic              cfg_ext,
    input  logic              cfg_eob,
    input  logic [31:0]       cfg_sid,
    input  word_cls_t         cls,
    input  logic [IDX_W-1:0]  bidx,
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  nfull,
    output logic              mis_head,
    output logic              mis_time,
    output logic              mis_pay
);
    localparam int BYTES = DATA_W / 8;
    localparam int LANES = DATA_W / 16;
    localparam int BI_W  = $clog2(BYTES);

    logic [SIZE_W:0]   size_x, start_b, span;
    logic [15:0]       lane_base;
    logic [DATA_W-1:0] pattern, tail_mask, head_word;
    logic [BI_W:0]     tail_bytes;

    // full payload words: byte positions from start, step 8, below size
    assign size_x  = {1'b0, cfg_size};
    assign start_b = cfg_has_time ? (SIZE_W+1)'(24) : (SIZE_W+1)'(16);
    assign span    = size_x - start_b;
    assign nfull   = (size_x > start_b) ? IDX_W'((span + (SIZE_W+1)'(7)) >> 3) : '0;

    assign lane_base = 16'(bidx << 2);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            assign pattern[DATA_W-1-16*l -: 16] = lane_base + 16'(l);
        end
    endgenerate

    assign tail_bytes = (cfg_size[BI_W-1:0] == '0) ? (BI_W+1)'(BYTES)
                                                   : {1'b0, cfg_size[BI_W-1:0]};

    genvar b;
    generate
        for (b = 0; b < BYTES; b++) begin : g_mask
            assign tail_mask[8*b +: 8] =
                ((BI_W+1)'(BYTES - 1 - b) < tail_bytes) ? 8'hFF : 8'h00;
        end
    endgenerate

    assign head_word = {cfg_ext, 1'b0, cfg_has_time, cfg_eob, cfg_seq_id, cfg_size, cfg_sid};

    assign mis_head = (cls == WC_HEAD) && (data != head_word);
    assign mis_time = (cls == WC_TIME) && (data != cfg_time);
    assign mis_pay  = ((cls == WC_BODY) && (data != pattern)) ||
                      ((cls == WC_TAIL) && (((data ^ pattern) & tail_mask) != '0));

endmodule

// File: rtl/pkt_chk_fsm.sv
module pkt_chk_fsm
    import pkt_chk_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             last,
    input  logic             has_time,
    input  logic [IDX_W-1:0] nfull,
    output word_cls_t        cls,
    output logic [IDX_W-1:0] bidx,
    output logic             frame_bad
);
    chk_state_t state, nxt;

    // state register with payload word index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HEAD;
            bidx  <= '0;
        end else begin
            state <= nxt;
            if (acc) begin
                if (state == ST_HEAD)
                    bidx <= '0;
                else if (state == ST_BODY)
                    bidx <= bidx + IDX_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (acc) begin
            unique case (state)
                ST_HEAD: begin
                    if (last)             nxt = ST_HEAD;
                    else if (has_time)    nxt = ST_TIME;
                    else if (nfull != '0) nxt = ST_BODY;
                    else                  nxt = ST_TAIL;
                end
                ST_TIME: begin
                    if (last)             nxt = ST_HEAD;
                    else if (nfull != '0) nxt = ST_BODY;
                    else                  nxt = ST_TAIL;
                end
                ST_BODY: begin
                    if (last)                               nxt = ST_HEAD;
                    else if ((bidx + IDX_W'(1)) == nfull)   nxt = ST_TAIL;
                    else                                    nxt = ST_BODY;
                end
                ST_TAIL:  nxt = last ? ST_HEAD : ST_DRAIN;
                ST_DRAIN: nxt = last ? ST_HEAD : ST_DRAIN;
                default:  nxt = ST_HEAD;
            endcase
        end
    end

    // outputs: word class and framing decision
    always_comb begin
        cls       = WC_EXTRA;
        frame_bad = 1'b0;
        unique case (state)
            ST_HEAD:  begin cls = WC_HEAD;  frame_bad = acc && last;  end
            ST_TIME:  begin cls = WC_TIME;  frame_bad = acc && last;  end
            ST_BODY:  begin cls = WC_BODY;  frame_bad = acc && last;  end
            ST_TAIL:  begin cls = WC_TAIL;  frame_bad = acc && !last; end
            ST_DRAIN: begin cls = WC_EXTRA; frame_bad = 1'b0;         end
            default:  begin cls = WC_EXTRA; frame_bad = 1'b0;         end
        endcase
    end

endmodule

// File: rtl/pkt_chk_errs.sv
module pkt_chk_errs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             acc,
    input  logic             last,
    input  logic             mis_head,
    input  logic             mis_time,
    input  logic             mis_pay,
    input  logic             frame_bad,
    output logic             err_header,
    output logic             err_time,
    output logic             err_payload,
    output logic             err_frame,
    output logic [CNT_W-1:0] err_count,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic word_bad;
    assign word_bad = acc && (mis_head || mis_time || mis_pay);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_header  <= 1'b0;
            err_time    <= 1'b0;
            err_payload <= 1'b0;
            err_frame   <= 1'b0;
            err_count   <= '0;
            done        <= 1'b0;
        end else begin
            done <= acc && last;
            if (clear) begin
                err_header  <= 1'b0;
                err_time    <= 1'b0;
                err_payload <= 1'b0;
                err_frame   <= 1'b0;
                err_count   <= '0;
            end else begin
                if (acc && mis_head) err_header  <= 1'b1;
                if (acc && mis_time) err_time    <= 1'b1;
                if (acc && mis_pay)  err_payload <= 1'b1;
                if (frame_bad)       err_frame   <= 1'b1;
                if (word_bad && (err_count != CNT_MAX))
                    err_count <= err_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pkt_checker.sv
module pkt_checker
    import pkt_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [11:0]      cfg_seq_id,
    input  logic [15:0]      cfg_size,
    input  logic             cfg_has_time,
    input  logic [63:0]      cfg_time,
    input  logic             cfg_ext,
    input  logic             cfg_eob,
    input  logic [31:0]      cfg_sid,
    input  logic [63:0]      s_data,
    input  logic             s_last,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             err_header,
    output logic             err_time,
    output logic             err_payload,
    output logic             err_frame,
    output logic [CNT_W-1:0] err_count,
    output logic             done
);
    localparam int DATA_W = 64;
    localparam int SIZE_W = 16;
    localparam int IDX_W  = SIZE_W;

    logic             acc, mis_head, mis_time, mis_pay, frame_bad;
    logic [IDX_W-1:0] nfull, bidx;
    word_cls_t        cls;

    assign s_ready = rst_n;
    assign acc     = s_valid && s_ready;

    pkt_chk_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .last      (s_last),
        .has_time  (cfg_has_time),
        .nfull     (nfull),
        .cls       (cls),
        .bidx      (bidx),
        .frame_bad (frame_bad)
    );

    pkt_chk_expect #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_expect (
        .cfg_seq_id   (cfg_seq_id),
        .cfg_size     (cfg_size),
        .cfg_has_time (cfg_has_time),
        .cfg_time     (cfg_time),
        .cfg_ext      (cfg_ext),
        .cfg_eob      (cfg_eob),
        .cfg_sid      (cfg_sid),
        .cls          (cls),
        .bidx         (bidx),
        .data         (s_data),
        .nfull        (nfull),
        .mis_head     (mis_head),
        .mis_time     (mis_time),
        .mis_pay      (mis_pay)
    );

    pkt_chk_errs #(.CNT_W(CNT_W)) u_errs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .acc         (acc),
        .last        (s_last),
        .mis_head    (mis_head),
        .mis_time    (mis_time),
        .mis_pay     (mis_pay),
        .frame_bad   (frame_bad),
        .err_header  (err_header),
        .err_time    (err_time),
        .err_payload (err_payload),
        .err_frame   (err_frame),
        .err_count   (err_count),
        .done        (done)
    );

endmodule

// File: rtl/pkt_checker_sva.sv
module pkt_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             s_valid,
    input logic             s_last,
    input logic             err_header,
    input logic             err_time,
    input logic             err_payload,
    input logic             err_frame,
    input logic [CNT_W-1:0] err_count,
    input logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(s_valid && s_last)); // R10

    AST_HEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_header && !clear) |=> err_header); // R8

    AST_TIME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_time && !clear) |=> err_time); // R8

    AST_PAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_payload && !clear) |=> err_payload); // R8

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !clear) |=> err_frame); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (err_count == '0) && !err_header && !err_time && !err_payload && !err_frame); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + CNT_W'(1))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_count == CNT_MAX) && !clear) |=> (err_count == CNT_MAX)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_valid && !clear) |=> $stable(err_count) && $stable(err_frame) && !done); // R1

endmodule

bind pkt_checker pkt_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .s_valid     (s_valid),
    .s_last      (s_last),
    .err_header  (err_header),
    .err_time    (err_time),
    .err_payload (err_payload),
    .err_frame   (err_frame),
    .err_count   (err_count),
    .done        (done)
);

// File: tb/pkt_checker_bench.sv
module pkt_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [11:0] cfg_seq_id = 12'h5A3;
    logic [15:0] cfg_size = 16'd40;
    logic        cfg_has_time = 1'b0;
    logic [63:0] cfg_time = 64'h0123_4567_89AB_CDEF;
    logic        cfg_ext = 1'b1;
    logic        cfg_eob = 1'b1;
    logic [31:0] cfg_sid = 32'hC0DE_0042;
    logic [63:0] s_data = '0;
    logic        s_last = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        err_header, err_time, err_payload, err_frame, done;
    logic [15:0] err_count;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pkt_checker u_pkt_checker (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .cfg_seq_id(cfg_seq_id), .cfg_size(cfg_size), .cfg_has_time(cfg_has_time),
        .cfg_time(cfg_time), .cfg_ext(cfg_ext), .cfg_eob(cfg_eob), .cfg_sid(cfg_sid),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready),
        .err_header(err_header), .err_time(err_time), .err_payload(err_payload),
        .err_frame(err_frame), .err_count(err_count), .done(done)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic chk_state(input string rq, input logic h, input logic t, input logic p,
                             input logic f, input logic [15:0] cnt);
        chk({rq, " flags"}, {60'd0, err_header, err_time, err_payload, err_frame}, {60'd0, h, t, p, f});
        chk({rq, " count"}, {48'd0, err_count}, {48'd0, cnt});
    endtask

    function automatic logic [63:0] lanes(input logic [15:0] j);
        return {j, j + 16'd1, j + 16'd2, j + 16'd3};
    endfunction

    function automatic int full_words(input logic ht, input int size);
        int n = 0;
        for (int i = (ht ? 24 : 16); i < size; i += 8) n++;
        return n;
    endfunction

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // send one packet; word bad_w gets flip xored in; last on word last_w (-1: on final word)
    task automatic run_pkt(input int bad_w, input logic [63:0] flip, input int last_w, input int gap);
        int nf  = full_words(cfg_has_time, cfg_size);
        int fin = 1 + (cfg_has_time ? 1 : 0) + nf;
        int lw  = (last_w < 0) ? fin : last_w;
        for (int w = 0; w <= lw; w++) begin
            logic [63:0] d;
            int k;
            k = w - 1 - (cfg_has_time ? 1 : 0);
            if (w == 0)                    d = {cfg_ext, 1'b0, cfg_has_time, cfg_eob, cfg_seq_id, cfg_size, cfg_sid};
            else if (cfg_has_time && w == 1) d = cfg_time;
            else if (w <= fin)             d = lanes(16'(4 * k));
            else                           d = 64'hFACE_FACE_FACE_FACE;
            if (w == bad_w) d = d ^ flip;
            s_valid = 1'b1; s_data = d; s_last = (w == lw);
            @(negedge clk);
            s_valid = 1'b0;
            if (w != lw) begin
                for (int g = 0; g < gap; g++) begin
                    s_data = ~d; s_last = 1'b1;
                    @(negedge clk);
                end
            end
            s_last = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 ready", {63'd0, s_ready}, 64'd1);
        chk_state("R8 reset", 0, 0, 0, 0, 16'd0);
        chk("R10 reset done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_good_no_time();
        cfg_has_time = 1'b0; cfg_size = 16'd40;
        run_pkt(-1, '0, -1, 0);
        chk("R10 done pulse", {63'd0, done}, 64'd1);
        chk_state("R4 R5 good packet", 0, 0, 0, 0, 16'd0);
        @(negedge clk);
        chk("R10 done single", {63'd0, done}, 64'd0);
    endtask

    task automatic t_gaps();
        cfg_has_time = 1'b1; cfg_size = 16'd56;
        run_pkt(-1, '0, -1, 3);
        chk("R10 done after gaps", {63'd0, done}, 64'd1);
        chk_state("R1 idle inputs ignored", 0, 0, 0, 0, 16'd0);
    endtask

    task automatic t_tail_mask();
        cfg_has_time = 1'b1; cfg_size = 16'd37;   // 2 full words, tail j=8, top 5 bytes
        run_pkt(4, 64'h0000_0000_00FF_FFFF, -1, 0);
        chk_state("R6 bytes past size ignored", 0, 0, 0, 0, 16'd0);
        run_pkt(4, 64'h0000_0000_FF00_0000, -1, 0);
        chk_state("R6 last valid byte compared", 0, 0, 1, 0, 16'd1);
        do_clear();
        chk_state("R8 clear", 0, 0, 0, 0, 16'd0);
    endtask

    task automatic t_small();
        cfg_has_time = 1'b0; cfg_size = 16'd8;    // no full words, tail j=0, 8 bytes
        run_pkt(1, 64'h0000_0000_0000_0001, -1, 0);
        chk_state("R5 R6 size below start", 0, 0, 1, 0, 16'd1);
        do_clear();
        cfg_size = 16'd20;                        // one full word, tail j=4
        run_pkt(-1, '0, -1, 0);
        chk_state("R5 one full word", 0, 0, 0, 0, 16'd0);
        run_pkt(1, 64'h0001_0000_0000_0000, -1, 0);
        chk_state("R4 lane j in top bits", 0, 0, 1, 0, 16'd1);
        do_clear();
    endtask

    task automatic t_header_time();
        cfg_has_time = 1'b1; cfg_size = 16'd48;
        run_pkt(0, 64'h0000_0000_0000_0100, -1, 0);
        chk_state("R2 header sid mismatch", 1, 0, 0, 0, 16'd1);
        run_pkt(0, 64'h4000_0000_0000_0000, -1, 0);
        chk_state("R2 reserved bit", 1, 0, 0, 0, 16'd2);
        do_clear();
        run_pkt(1, 64'h8000_0000_0000_0000, -1, 0);
        chk_state("R3 time mismatch", 0, 1, 0, 0, 16'd1);
        do_clear();
        cfg_has_time = 1'b0;
        run_pkt(1, 64'h0000_0000_0000_0002, -1, 0);
        chk_state("R3 no time: word 1 is payload", 0, 0, 1, 0, 16'd1);
        do_clear();
    endtask

    task automatic t_framing();
        cfg_has_time = 1'b0; cfg_size = 16'd40;   // final word index 4
        run_pkt(-1, '0, 2, 0);
        chk("R10 done on early last", {63'd0, done}, 64'd1);
        chk_state("R7 early last", 0, 0, 0, 1, 16'd0);
        run_pkt(-1, '0, -1, 0);
        chk_state("R11 R8 next packet clean, frame sticky", 0, 0, 0, 1, 16'd0);
        do_clear();
        run_pkt(-1, '0, 6, 0);
        chk_state("R7 late last, extras not compared", 0, 0, 0, 1, 16'd0);
        do_clear();
        // clear in same cycle as a bad word: clear wins
        s_valid = 1'b1; s_last = 1'b1; s_data = '0; clear = 1'b1;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; clear = 1'b0;
        chk_state("R8 clear wins", 0, 0, 0, 0, 16'd0);
    endtask

    task automatic t_saturate();
        cfg_has_time = 1'b0; cfg_size = 16'd16;
        s_data = '0; s_last = 1'b1; s_valid = 1'b1;
        for (int i = 0; i < 65540; i++) @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        chk_state("R9 saturate", 1, 0, 0, 1, 16'hFFFF);
        do_clear();
        s_valid = 1'b1; s_last = 1'b1;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        chk_state("R9 count after clear", 1, 0, 0, 1, 16'd1);
        do_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_no_time();
        t_gaps();
        t_tail_mask();
        t_small();
        t_header_time();
        t_framing();
        t_saturate();
        chk("R1 ready at end", {63'd0, s_ready}, 64'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule